// File: doc/BRIEF.md
# Mixed-Width Function Unit Wait Matrix

This block tracks, for a scoreboarded pipeline, which Function Units each busy unit still waits on before it may read its operands. It has a square grid of one-bit cells, with one row and one column per unit. A set cell in row i, column j means unit i needs a result that unit j has not yet produced. The units fall into two width classes. Indices 0 to N32-1 are 32-bit units and indices N32 to N32+N8-1 are 8-bit units. Any unit may wait on any other unit, whatever its class.

An issue request names a target unit and a producer vector. The producer bits are latched into the target's row, and the target is marked busy. A completion pulse from a unit wipes its column in every row. The same pulse frees that unit. A unit's ready output rises once it is busy and its row is empty.

A 64-bit operation takes an even-numbered 32-bit unit and the unit just above it. Both rows receive the union of the two halves' producer vectors. The two units are freed together.

Top module: `fu_dep_matrix`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `ready` and `iss_err` are all zero.
- R2: An accepted issue to unit u sets `busy[u]` from the next cycle and loads row u with the producer vector. Bits naming units that are idle, that are being freed that cycle, or that are the target itself are dropped.
- R3: `ready[i]` is high exactly when unit i is busy and row i has no set bit once that cycle's completion clears are applied. A completion arriving in the same cycle therefore raises `ready` combinationally.
- R4: A `done[j]` pulse while unit j is busy clears column j in every row and frees unit j, so `busy[j]` is low from the next cycle. A pulse on an idle unit changes nothing.
- R5: Dependencies work the same way within a width class and across width classes. A 32-bit unit (index below N32) may wait on an 8-bit unit (index N32 or above), and the reverse also holds, including chains that alternate between classes.
- R6: An issue to a unit that is already busy is refused. `iss_err` is high in that same cycle, and no busy bit or row is changed.
- R7: A wide issue (`iss_wide`=1) to an even unit u below N32 marks u and u+1 busy. Both rows receive the union of `iss_prod` and `iss_prod_hi`, with u and u+1 removed. Both units therefore report `ready` in the same cycle.
- R8: A wide issue is refused with `iss_err` in these cases: the unit index is odd, the unit index is N32 or above, or either unit of the pair is busy.
- R9: A completion pulse on either unit of a wide pair frees both units and clears both of their columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_wide | input | 1 | Request is a 64-bit pair issue |
| iss_unit | input | IW | Target unit (lower unit of a pair) |
| iss_prod | input | N | Producer vector (lower half for a pair) |
| iss_prod_hi | input | N | Upper-half producer vector, used only for pair issues |
| done | input | N | Per-unit completion pulse |
| busy | output | N | Per-unit occupied flag |
| ready | output | N | Per-unit permission to read operands |
| iss_err | output | 1 | Issue request refused this cycle |

## Verification
The main check sweeps every ordered pair of a consumer and a distinct producer across all 16 units. For each pair it confirms that the consumer is held, that `ready` rises in the cycle of the completion pulse, and that the producer is freed. Pairs where the two units are in different width classes separate a correct shared grid from one that only links units of the same width. A four-stage chain alternating between classes shows that each completion releases only the next waiter in the chain. Wide-pair issues with two different half vectors show that the union is taken rather than just one half. A completion on one half confirms that both halves are freed. Refused issues, idle producers and stray completions confirm that the state they could have touched stays unchanged.

// File: rtl/fu_dep_matrix.sv
module fu_dep_matrix #(
  parameter int N32 = 8,
  parameter int N8  = 8,
  localparam int N  = N32 + N8,
  localparam int IW = $clog2(N),
  localparam int NP = N32 / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic          iss_wide,
  input  logic [IW-1:0] iss_unit,
  input  logic [N-1:0]  iss_prod,
  input  logic [N-1:0]  iss_prod_hi,
  input  logic [N-1:0]  done,
  output logic [N-1:0]  busy,
  output logic [N-1:0]  ready,
  output logic          iss_err
);

  logic [N-1:0] dep_q [N];
  logic [N-1:0] busy_q;
  logic [NP-1:0] pair_q;
  logic [N-1:0] rel_raw, rel, live, tgt, prod;
  logic [IW-1:0] uhi;
  logic wide_ok, reject, accept;

  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  assign rel_raw = done & busy_q;

  always_comb begin
    rel = rel_raw;
    for (int k = 0; k < NP; k++)
      if (pair_q[k] && (rel_raw[2*k] || rel_raw[2*k+1])) begin
        rel[2*k]   = 1'b1;
        rel[2*k+1] = 1'b1;
      end
  end

  assign live    = busy_q & ~rel;
  assign uhi     = iss_unit + IW'(1);
  assign wide_ok = (iss_unit < IW'(N32)) && !iss_unit[0];
  assign tgt     = (ONE << iss_unit) | (iss_wide ? (ONE << uhi) : '0);
  assign reject  = iss_valid && (iss_wide ? (!wide_ok || |(busy_q & tgt))
                                          : busy_q[iss_unit]);
  assign accept  = iss_valid && !reject;
  assign prod    = (iss_prod | (iss_wide ? iss_prod_hi : '0)) & live & ~tgt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
      pair_q <= '0;
      for (int i = 0; i < N; i++) dep_q[i] <= '0;
    end else begin
      busy_q <= live | (accept ? tgt : '0);
      for (int i = 0; i < N; i++)
        dep_q[i] <= (accept && tgt[i]) ? prod : (dep_q[i] & ~rel);
      for (int k = 0; k < NP; k++)
        if (accept && iss_wide && iss_unit == IW'(2*k)) pair_q[k] <= 1'b1;
        else if (rel[2*k])                            pair_q[k] <= 1'b0;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_rdy
    assign ready[i] = busy_q[i] & ~|(dep_q[i] & ~rel);
  end

  assign busy    = busy_q;
  assign iss_err = reject;

endmodule

// File: rtl/fu_dep_matrix_chk.sv
module fu_dep_matrix_chk #(
  parameter int N32 = 8,
  parameter int N8  = 8,
  localparam int N  = N32 + N8,
  localparam int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iss_valid,
  input logic          iss_wide,
  input logic [IW-1:0] iss_unit,
  input logic [N-1:0]  done,
  input logic [N-1:0]  busy,
  input logic [N-1:0]  ready,
  input logic          iss_err
);

  p_ready_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready & ~busy) == '0);

  p_issue_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_err |=> busy[$past(iss_unit)]);

  p_reject_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_err && done == '0 |=> busy == $past(busy));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done & busy) != '0 |=> (busy & $past(done & busy)) == '0);

  p_wide_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_wide && !iss_err |=>
      busy[$past(iss_unit)] && busy[$past(iss_unit) + IW'(1)]);

  p_wide_bad_r8: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_wide && (iss_unit[0] || iss_unit >= IW'(N32)) |-> iss_err);

endmodule

bind fu_dep_matrix fu_dep_matrix_chk #(.N32(N32), .N8(N8)) chk_i (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_wide(iss_wide),
  .iss_unit(iss_unit), .done(done), .busy(busy), .ready(ready),
  .iss_err(iss_err)
);

// File: tb/fu_dep_matrix_tb_top.sv
module fu_dep_matrix_tb_top;
  logic clk = 0, rst_n = 0;
  logic iss_valid = 0, iss_wide = 0;
  logic [3:0] iss_unit = 0;
  logic [15:0] iss_prod = 0, iss_prod_hi = 0, done = 0;
  logic [15:0] busy, ready;
  logic iss_err;
  logic [15:0] s_ready;
  logic s_err;
  int tests = 0, fails = 0, cyc = 0;

  fu_dep_matrix dut_i (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [3:0] u, input logic w,
                       input logic [15:0] p, input logic [15:0] ph, input logic [15:0] d);
    @(negedge clk);
    iss_valid = v; iss_unit = u; iss_wide = w; iss_prod = p; iss_prod_hi = ph; done = d;
    #2;
    s_ready = ready; s_err = iss_err;
    @(posedge clk); #1;
    iss_valid = 0; iss_wide = 0; iss_prod = 0; iss_prod_hi = 0; done = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 busy", busy, 0); chk("R1 ready", ready, 0); chk("R1 err", iss_err, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R1 after", busy | ready, 0);

    for (int c = 0; c < 16; c++)
      for (int p = 0; p < 16; p++)
        if (p != c) begin
          string rq;
          rq = ((c < 8) != (p < 8)) ? "R5" : "R3";
          drive(1, 4'(p), 0, 0, 0, 0);
          chk("R2", busy, 16'(1) << p); chk("R3", ready, 16'(1) << p);
          drive(1, 4'(c), 0, 16'(1) << p, 0, 0);
          chk("R2", busy, (16'(1) << p) | (16'(1) << c)); chk(rq, ready, 16'(1) << p);
          drive(0, 0, 0, 0, 0, 16'(1) << p);
          chk(rq, 32'(s_ready[c]), 1);
          chk("R4", busy, 16'(1) << c); chk("R4", ready, 16'(1) << c);
          drive(0, 0, 0, 0, 0, 16'(1) << c);
          chk("R4", busy, 0);
        end

    drive(1, 3, 0, 16'hFFFF, 0, 0);
    chk("R2 idle/self dropped", ready, 16'h0008);
    drive(0, 0, 0, 0, 0, 16'h0008);

    drive(1, 9, 0, 0, 0, 0);
    drive(1, 2, 0, 16'h0200, 0, 0);
    drive(0, 0, 0, 0, 0, 16'h0020);
    chk("R4 idle done", busy, 16'h0204); chk("R4 idle done", ready, 16'h0200);
    drive(1, 9, 0, 16'h0004, 0, 0);
    chk("R6 err", s_err, 1); chk("R6 busy", busy, 16'h0204); chk("R6 row", ready, 16'h0200);
    drive(0, 0, 0, 0, 0, 16'h0204);
    chk("R4", busy, 0);

    drive(1, 10, 0, 0, 0, 0);
    drive(1, 4, 0, 16'h0400, 0, 0);
    drive(1, 12, 0, 16'h0010, 0, 0);
    drive(1, 1, 0, 16'h1400, 0, 0);
    chk("R5 chain", ready, 16'h0400);
    drive(0, 0, 0, 0, 0, 16'h0400);
    chk("R5 chain", ready, 16'h0010);
    drive(0, 0, 0, 0, 0, 16'h0010);
    chk("R5 chain", ready, 16'h1000);
    drive(0, 0, 0, 0, 0, 16'h1000);
    chk("R5 chain", ready, 16'h0002);
    drive(0, 0, 0, 0, 0, 16'h0002);
    chk("R5 chain", busy, 0);

    drive(1, 15, 0, 0, 0, 0);
    drive(1, 6, 0, 0, 0, 0);
    drive(1, 2, 1, 16'h8000, 16'h0040, 0);
    chk("R7 busy", busy, 16'h804C); chk("R7 ready", ready, 16'h8040);
    drive(0, 0, 0, 0, 0, 16'h8000);
    chk("R7 union", ready, 16'h0040);
    drive(0, 0, 0, 0, 0, 16'h0040);
    chk("R7 both", ready, 16'h000C);
    drive(1, 8, 0, 16'h0008, 0, 0);
    chk("R9 wait", ready, 16'h000C);
    drive(0, 0, 0, 0, 0, 16'h0004);
    chk("R9 both freed", busy, 16'h0100); chk("R9 column", ready, 16'h0100);
    drive(0, 0, 0, 0, 0, 16'h0100);

    drive(1, 5, 1, 0, 0, 0);
    chk("R8 odd", s_err, 1); chk("R8 odd", busy, 0);
    drive(1, 10, 1, 0, 0, 0);
    chk("R8 narrow", s_err, 1); chk("R8 narrow", busy, 0);
    drive(1, 1, 0, 0, 0, 0);
    drive(1, 0, 1, 0, 0, 0);
    chk("R8 half busy", s_err, 1); chk("R8 half busy", busy, 16'h0002);
    drive(0, 0, 0, 0, 0, 16'h0002);

    drive(1, 4, 1, 16'h0020, 16'h0010, 0);
    chk("R7 self", s_err, 0); chk("R7 self", ready, 16'h0030);
    drive(0, 0, 0, 0, 0, 16'h0020);
    chk("R9 hi done", busy, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule